// File: doc/BRIEF.md
# Configurable Ripple Arithmetic Slice

This block is an 8-bit arithmetic slice built around one bit-level ripple carry chain. Each bit of the chain forms a propagate and a generate term. The propagate term decides whether the incoming carry passes through to that bit's carry-out. When the carry does not pass through, the generate term supplies the carry-out. The same chain serves two submodes. In arithmetic mode it adds or subtracts two operand buses. In counter mode it increments or decrements the slice's own count register, which can be loaded in parallel.

The slice can run as a single 8-bit unit or be split into two independent 4-bit nibbles. Each nibble has its own control bit. The control bit selects add or subtract in arithmetic mode, and up or down in counter mode. Each nibble also has its own carry output. A registered copy of the carry outputs is kept, and it is captured only on edges where the count advances. Subtraction is performed as A plus the inverted B with a forced carry-in of 1. A carry-out of 1 therefore means that no borrow occurred.

Top module: `ripple_arith_slice`

## Requirements
- R1: In arithmetic mode (cnt_mode_i=0) with ctl bit 0, a segment returns A+B+cin_i on result_o, and the segment's carry-out is the carry out of its top bit.
- R2: In arithmetic mode with ctl bit 1, a segment returns A-B modulo 2^width, cin_i is ignored, and the segment's carry-out is 1 exactly when A >= B, meaning no borrow.
- R3: With split_i=0 the slice is one 8-bit unit. ctl_i[0] controls the whole slice and ctl_i[1] is ignored. The carry from bit 3 feeds bit 4. cout_o[0] is the carry out of bit 3 and cout_o[1] is the carry out of bit 7.
- R4: With split_i=1 the nibbles are independent. The low nibble (bits 3:0) uses ctl_i[0] and the high nibble (bits 7:4) uses ctl_i[1]. The high nibble's chain starts from its own carry-in (cin_i when adding), not from bit 3. cout_o[0] and cout_o[1] are the nibble carry-outs.
- R5: In counter mode result_o combinationally shows the count q_o plus or minus one, and a_i, b_i and cin_i are ignored. On each clock edge without a load, q_o takes that value.
- R6: A counter control bit of 0 counts up and 1 counts down, applied per segment. Counting up, the carry-out is 1 when the segment wraps from all ones to zero. Counting down, the carry-out is 0 only when the segment wraps from zero to all ones.
- R7: load_i=1 loads din_i into q_o on the next edge in either mode and takes priority over counting. reg_cout_o holds on that edge.
- R8: reg_cout_o captures cout_o on each edge where the count advances (cnt_mode_i=1 and load_i=0) and holds on every other edge.
- R9: In arithmetic mode without a load, q_o holds its value.
- R10: The asynchronous active-low reset clears q_o and reg_cout_o to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_mode_i | input | 1 | 0 = arithmetic mode, 1 = counter mode |
| split_i | input | 1 | 1 = two independent nibbles, 0 = one 8-bit unit |
| ctl_i | input | 2 | Per-nibble control: subtract or count down when 1 |
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B |
| cin_i | input | 1 | External carry-in for addition |
| load_i | input | 1 | Parallel load enable |
| din_i | input | 8 | Parallel load data |
| result_o | output | 8 | Combinational result bus |
| q_o | output | 8 | Count register |
| cout_o | output | 2 | Combinational carry-outs of bit 3 and bit 7 |
| reg_cout_o | output | 2 | Registered carry-outs |

## Verification
result_o and cout_o are purely combinational. Their checks are sampled a short settle delay after the inputs are driven on the falling edge, inside the same cycle. q_o and reg_cout_o change one rising edge after the stimulus, so the bench checks them at the following falling edge. This gives each count step, load and hold exactly one edge to act. Counter results combine both timings: the bench checks the combinational next value first, and then checks that q_o and reg_cout_o took that value and carry after one edge.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic {
    MODE_ARITH = 1'b0,
    MODE_COUNT = 1'b1
  } ras_mode_e;

  // carry that starts a segment when not cascaded
  function automatic logic seg_start_carry(input logic cnt, input logic ctl, input logic cin_ext);
    if (cnt) return ~ctl;          // up: +1 via carry, down: add all-ones
    else     return ctl ? 1'b1 : cin_ext;
  endfunction
endpackage

// File: rtl/ras_bit_cell.sv
module ras_bit_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic ci_i,
  output logic s_o,
  output logic co_o
);
  logic prop, gen;
  assign prop = x_i ^ y_i;
  assign gen  = x_i & y_i;
  assign co_o = prop ? ci_i : gen;
  assign s_o  = prop ^ ci_i;
endmodule

// File: rtl/ras_nibble.sv
module ras_nibble #(
  parameter int unsigned NIB_W = 4
) (
  input  logic             cnt_i,
  input  logic             ctl_i,
  input  logic [NIB_W-1:0] opa_i,
  input  logic [NIB_W-1:0] opb_i,
  input  logic             cin_ext_i,
  input  logic             cin_chain_i,
  input  logic             cascade_i,
  output logic [NIB_W-1:0] sum_o,
  output logic             co_o
);
  import ras_pkg::*;

  logic [NIB_W-1:0] y_eff;
  logic [NIB_W:0]   chain;

  always_comb begin
    if (cnt_i)      y_eff = {NIB_W{ctl_i}};
    else if (ctl_i) y_eff = ~opb_i;
    else            y_eff = opb_i;
  end

  assign chain[0] = cascade_i ? cin_chain_i : seg_start_carry(cnt_i, ctl_i, cin_ext_i);

  for (genvar i = 0; i < NIB_W; i++) begin : g_cell
    ras_bit_cell u_cell (
      .x_i (opa_i[i]),
      .y_i (y_eff[i]),
      .ci_i(chain[i]),
      .s_o (sum_o[i]),
      .co_o(chain[i+1])
    );
  end

  assign co_o = chain[NIB_W];
endmodule

// File: rtl/ras_count_reg.sv
module ras_count_reg #(
  parameter int unsigned W     = 8,
  parameter int unsigned NSEG  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cnt_i,
  input  logic            load_i,
  input  logic [W-1:0]    din_i,
  input  logic [W-1:0]    next_i,
  input  logic [NSEG-1:0] co_i,
  output logic [W-1:0]    q_o,
  output logic [NSEG-1:0] rco_o
);
  logic advance;
  assign advance = cnt_i & ~load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= '0;
      rco_o <= '0;
    end else begin
      if (load_i)       q_o <= din_i;
      else if (advance) q_o <= next_i;
      if (advance)      rco_o <= co_i;
    end
  end

  AST_LOAD_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (q_o == $past(din_i))); // R7
  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance |=> (q_o == $past(next_i))); // R5
  AST_RCO_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance |=> (rco_o == $past(co_i))); // R8
  AST_RCO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !advance |=> $stable(rco_o)); // R8
  AST_ARITH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_i && !load_i) |=> $stable(q_o)); // R9
endmodule

// File: rtl/ripple_arith_slice.sv
module ripple_arith_slice #(
  parameter int unsigned NIB_W   = 4,
  parameter int unsigned NUM_NIB = 2,
  localparam int unsigned W      = NIB_W * NUM_NIB
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cnt_mode_i,
  input  logic               split_i,
  input  logic [NUM_NIB-1:0] ctl_i,
  input  logic [W-1:0]       a_i,
  input  logic [W-1:0]       b_i,
  input  logic               cin_i,
  input  logic               load_i,
  input  logic [W-1:0]       din_i,
  output logic [W-1:0]       result_o,
  output logic [W-1:0]       q_o,
  output logic [NUM_NIB-1:0] cout_o,
  output logic [NUM_NIB-1:0] reg_cout_o
);
  import ras_pkg::*;

  ras_mode_e      mode;
  logic [W-1:0]   opa;
  logic [W-1:0]   next_val;
  logic [NUM_NIB-1:0] seg_ctl;

  assign mode = cnt_mode_i ? MODE_COUNT : MODE_ARITH;
  assign opa  = (mode == MODE_COUNT) ? q_o : a_i;

  for (genvar k = 0; k < NUM_NIB; k++) begin : g_nib
    logic chain_in;
    if (k == 0) begin : g_first
      assign chain_in = 1'b0;
    end else begin : g_rest
      assign chain_in = cout_o[k-1];
    end
    assign seg_ctl[k] = split_i ? ctl_i[k] : ctl_i[0];

    ras_nibble #(.NIB_W(NIB_W)) u_nib (
      .cnt_i      (mode == MODE_COUNT),
      .ctl_i      (seg_ctl[k]),
      .opa_i      (opa[k*NIB_W +: NIB_W]),
      .opb_i      (b_i[k*NIB_W +: NIB_W]),
      .cin_ext_i  (cin_i),
      .cin_chain_i(chain_in),
      .cascade_i  (~split_i && (k != 0)),
      .sum_o      (next_val[k*NIB_W +: NIB_W]),
      .co_o       (cout_o[k])
    );
  end

  assign result_o = next_val;

  ras_count_reg #(.W(W), .NSEG(NUM_NIB)) u_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_i (mode == MODE_COUNT),
    .load_i(load_i),
    .din_i (din_i),
    .next_i(next_val),
    .co_i  (cout_o),
    .q_o   (q_o),
    .rco_o (reg_cout_o)
  );

  AST_FULL_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_mode_i && !split_i && !ctl_i[0]) |->
      ({cout_o[NUM_NIB-1], result_o} == ({1'b0, a_i} + {1'b0, b_i} + (W+1)'(cin_i)))); // R1
  AST_FULL_SUB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_mode_i && !split_i && ctl_i[0]) |->
      ((result_o == W'(a_i - b_i)) && (cout_o[NUM_NIB-1] == (a_i >= b_i)))); // R2
  AST_FULL_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_mode_i && !split_i && !ctl_i[0]) |-> (result_o == W'(q_o + 1'b1))); // R6
  AST_FULL_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_mode_i && !split_i && ctl_i[0]) |-> (result_o == W'(q_o - 1'b1))); // R6
endmodule

// File: tb/ripple_arith_slice_test.sv
module ripple_arith_slice_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       cnt_mode = 0, split = 0, cin = 0, load = 0;
  logic [1:0] ctl = 0;
  logic [7:0] a = 0, b = 0, din = 0;
  logic [7:0] result, q;
  logic [1:0] cout, rcout;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ripple_arith_slice uut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_mode_i(cnt_mode), .split_i(split),
    .ctl_i(ctl), .a_i(a), .b_i(b), .cin_i(cin), .load_i(load), .din_i(din),
    .result_o(result), .q_o(q), .cout_o(cout), .reg_cout_o(rcout)
  );

  typedef struct packed {
    logic       sp;
    logic [1:0] c;
    logic [7:0] va;
    logic [7:0] vb;
    logic       ci;
    logic [7:0] res;
    logic [1:0] co;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'b00, 8'h12, 8'h34, 1'b0, 8'h46, 2'b00},  // R1
    '{1'b0, 2'b00, 8'hFF, 8'h01, 1'b0, 8'h00, 2'b11},  // R1 wrap
    '{1'b0, 2'b00, 8'h0F, 8'h00, 1'b1, 8'h10, 2'b01},  // R1 R3 bit3 carry
    '{1'b0, 2'b01, 8'h50, 8'h20, 1'b0, 8'h30, 2'b11},  // R2 no borrow
    '{1'b0, 2'b01, 8'h20, 8'h50, 1'b1, 8'hD0, 2'b01},  // R2 borrow, cin ignored
    '{1'b0, 2'b10, 8'h08, 8'h08, 1'b0, 8'h10, 2'b01},  // R3 ctl[1] ignored
    '{1'b1, 2'b00, 8'h9A, 8'h87, 1'b0, 8'h11, 2'b11},  // R4 no cascade
    '{1'b1, 2'b10, 8'h35, 8'h54, 1'b1, 8'hEA, 2'b00},  // R4 hi sub lo add
    '{1'b1, 2'b01, 8'h73, 8'h25, 1'b1, 8'hAE, 2'b00},  // R4 lo sub hi add
    '{1'b1, 2'b11, 8'h44, 8'h44, 1'b0, 8'h00, 2'b11}   // R4 both sub
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #35;
    chk("R10 q reset", q, 8'h00);
    chk("R10 rcout reset", rcout, 2'b00);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // arithmetic table
    for (int i = 0; i < NV; i++) begin
      split = VECS[i].sp; ctl = VECS[i].c; a = VECS[i].va; b = VECS[i].vb; cin = VECS[i].ci;
      #2;
      chk($sformatf("R1-4 vec%0d result", i), result, VECS[i].res);
      chk($sformatf("R1-4 vec%0d cout", i), cout, VECS[i].co);
      @(negedge clk);
    end
    chk("R9 q holds in arith mode", q, 8'h00);
    chk("R8 rcout holds in arith mode", rcout, 2'b00);

    // counter up, joined
    split = 0; ctl = 2'b00; load = 1; din = 8'hFE;
    step();
    chk("R7 load", q, 8'hFE);
    load = 0; cnt_mode = 1; #2;
    chk("R5 up next", result, 8'hFF);
    chk("R6 up cout", cout, 2'b00);
    step();
    chk("R5 up q", q, 8'hFF);
    chk("R8 rcout after step", rcout, 2'b00);
    #2;
    chk("R6 up wrap result", result, 8'h00);
    chk("R6 up wrap cout", cout, 2'b11);
    step();
    chk("R5 wrap q", q, 8'h00);
    chk("R8 rcout wrap", rcout, 2'b11);

    // counter down, joined; ctl[1] ignored
    ctl = 2'b01; #2;
    chk("R6 down from 0", result, 8'hFF);
    chk("R6 down borrow cout", cout, 2'b00);
    step();
    chk("R6 down q", q, 8'hFF);
    chk("R8 rcout down", rcout, 2'b00);
    #2;
    chk("R6 down no borrow", result, 8'hFE);
    chk("R6 down cout", cout, 2'b11);

    // split counter: low up, high down
    load = 1; din = 8'h0F; split = 1; ctl = 2'b10;
    step();
    chk("R7 load over count", q, 8'h0F);
    chk("R7 rcout holds on load", rcout, 2'b00);
    load = 0; #2;
    chk("R4 R6 split count result", result, 8'hF0);
    chk("R4 R6 split count cout", cout, 2'b01);
    step();
    chk("R5 split q", q, 8'hF0);
    chk("R8 split rcout", rcout, 2'b01);

    // counter ignores operand bus
    load = 1; din = 8'h5A; split = 0; ctl = 2'b00;
    step();
    load = 0; a = 8'hFF; b = 8'hFF; cin = 1; #2;
    chk("R5 operands ignored", result, 8'h5B);

    // arithmetic mode hold
    cnt_mode = 0;
    step();
    step();
    chk("R9 q hold", q, 8'h5A);
    chk("R8 rcout hold", rcout, 2'b01);

    // reset mid-run
    rst_n = 0; #2;
    chk("R10 async q", q, 8'h00);
    chk("R10 async rcout", rcout, 2'b00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule